// File: doc/BRIEF.md
# Store-and-Forward Packet FIFO

This block is an elastic buffer for framed packets between a MAC and its client, with both sides on one clock. Each beat of the 64-bit stream carries start and end markers, a count of unused bytes on the closing beat, and an error flag. Beats are accepted whenever the input handshake completes. A packet is offered on the output only after its closing beat has been stored, so a downstream consumer never sees a partial packet. A packet stops partway only when a buffer-full stall holds it back.

A static enable selects drop-on-error mode. The block samples the enable on each opening beat. In this mode a packet whose closing beat carries the error flag is removed in full. The write pointer goes back to the last committed boundary, so none of the packet's beats reach the output. A packet that would need more room than the whole buffer, with nothing complete stored ahead of it, is absorbed and discarded. This stops the input from stalling forever.

The write side is a three-state machine. In WR_IDLE it waits for an opening beat. In WR_BODY it collects a packet. In WR_SKIP it discards the rest of an oversize packet. Its transitions are:
- WR_IDLE to WR_BODY on an opening beat without the end marker.
- WR_BODY to WR_IDLE on the closing beat, which is kept or dropped.
- WR_BODY to WR_SKIP when the buffer is full and no complete packet is stored.
- WR_SKIP to WR_IDLE on the closing beat.

The read side has two states. RD_WAIT holds while no complete packet is stored. RD_SEND presents beats. RD_WAIT moves to RD_SEND once the complete-packet count is nonzero. RD_SEND returns to RD_WAIT after the last beat of the only complete packet, if no new packet commits in that cycle.

Top module: `pkt_sf_fifo`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Every kept packet leaves in arrival order, with each beat's data, start marker, end marker, 3-bit unused-byte count and error flag unchanged.
- R3: `out_valid` stays 0 until a packet's end-marked beat is stored. It first rises in the cycle after the second rising clock edge counted from, and including, the edge that accepts that beat.
- R4: If `drop_err_en` is 1 at a packet's opening beat and its end-marked beat has `in_err`=1, no beat of that packet appears on the output.
- R5: If `drop_err_en` is 0 at the opening beat, an errored packet is forwarded whole, with `out_err`=1 on its end-marked beat.
- R6: Changing `drop_err_en` after a packet's opening beat has no effect on that packet.
- R7: `in_ready` is 0 only when all DEPTH entries are occupied. While `out_valid`=1 and `out_ready`=0, the output beat is held stable.
- R8: If the buffer fills while a packet is open and no complete packet is stored, that packet's remaining beats are accepted and the whole packet is discarded. A packet of exactly DEPTH beats into an empty buffer is kept.
- R9: A beat that arrives while no packet is open and has `in_sop`=0 is accepted and discarded.
- R10: When the next complete packet is already stored, its first beat follows the previous packet's last beat with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| drop_err_en | input | 1 | Drop-on-error enable, sampled at each opening beat |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat may be taken |
| in_data | input | DATA_W | Input payload |
| in_sop | input | 1 | Opening beat of a packet |
| in_eop | input | 1 | Closing beat of a packet |
| in_empty | input | EMPTY_W | Unused bytes on the closing beat |
| in_err | input | 1 | Error flag, meaningful on the closing beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | DATA_W | Output payload |
| out_sop | output | 1 | Opening beat marker |
| out_eop | output | 1 | Closing beat marker |
| out_empty | output | EMPTY_W | Unused bytes on the closing beat |
| out_err | output | 1 | Error flag on the closing beat |

## Verification
The bench builds the block with 64-bit data and a depth of 16 entries rather than 512. With that depth, two short packets fill the buffer, so the full-buffer stall of `in_ready` and the held output beat can be checked directly. The oversize-packet discard is reached with a 20-beat packet, and the exact-depth packet that must still be kept with a 16-beat one.

// File: rtl/pkt_sf_fifo_pkg.sv
package pkt_sf_fifo_pkg;
    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_BODY = 2'd1,
        WR_SKIP = 2'd2
    } wr_state_e;

    typedef enum logic {
        RD_WAIT = 1'b0,
        RD_SEND = 1'b1
    } rd_state_e;
endpackage

// File: rtl/pkt_sf_fifo_ram.sv
module pkt_sf_fifo_ram #(
    parameter int WIDTH  = 70,
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_sf_fifo_wr_ctrl.sv
module pkt_sf_fifo_wr_ctrl
    import pkt_sf_fifo_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int PTR_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop_err_en,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic             in_err,
    input  logic [PTR_W-1:0] rptr,
    input  logic             pkt_avail,
    output logic             in_ready,
    output logic             we,
    output logic [PTR_W-1:0] wptr,
    output logic             commit
);
    localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);

    wr_state_e        state_q, state_d;
    logic [PTR_W-1:0] wptr_q, wptr_d;
    logic [PTR_W-1:0] cptr_q, cptr_d;
    logic             mode_q, mode_d;
    logic             full, accept, keep;

    assign full   = (wptr_q - rptr) == FULL_LVL;
    assign accept = in_valid && in_ready;
    // mode in force: live input on the opening beat, latched copy afterwards
    assign keep   = !(in_err && ((state_q == WR_IDLE) ? drop_err_en : mode_q));
    assign wptr   = wptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
            wptr_q  <= '0;
            cptr_q  <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wptr_q  <= wptr_d;
            cptr_q  <= cptr_d;
            mode_q  <= mode_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        wptr_d   = wptr_q;
        cptr_d   = cptr_q;
        mode_d   = mode_q;
        we       = 1'b0;
        commit   = 1'b0;
        in_ready = !full;
        unique case (state_q)
            WR_IDLE: begin
                if (accept && in_sop) begin
                    we     = 1'b1;
                    mode_d = drop_err_en;
                    if (in_eop) begin
                        if (keep) begin
                            wptr_d = wptr_q + 1'b1;
                            cptr_d = wptr_q + 1'b1;
                            commit = 1'b1;
                        end else begin
                            wptr_d = cptr_q;
                        end
                    end else begin
                        wptr_d  = wptr_q + 1'b1;
                        state_d = WR_BODY;
                    end
                end
            end
            WR_BODY: begin
                if (accept) begin
                    we = 1'b1;
                    if (in_eop) begin
                        state_d = WR_IDLE;
                        if (keep) begin
                            wptr_d = wptr_q + 1'b1;
                            cptr_d = wptr_q + 1'b1;
                            commit = 1'b1;
                        end else begin
                            wptr_d = cptr_q;
                        end
                    end else begin
                        wptr_d = wptr_q + 1'b1;
                    end
                end else if (full && !pkt_avail) begin
                    wptr_d  = cptr_q;
                    state_d = WR_SKIP;
                end
            end
            WR_SKIP: begin
                in_ready = 1'b1;
                if (accept && in_eop) begin
                    state_d = WR_IDLE;
                end
            end
            default: begin
                state_d = WR_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/pkt_sf_fifo_rd_ctrl.sv
module pkt_sf_fifo_rd_ctrl
    import pkt_sf_fifo_pkg::*;
#(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             out_ready,
    input  logic             rd_eop,
    output logic             out_valid,
    output logic [PTR_W-1:0] rptr,
    output logic [PTR_W-1:0] pkt_cnt
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    rd_state_e        state_q, state_d;
    logic [PTR_W-1:0] rptr_q, rptr_d;
    logic [PTR_W-1:0] cnt_q, cnt_d;
    logic             fire, last;

    assign fire    = out_valid && out_ready;
    assign last    = fire && rd_eop;
    assign rptr    = rptr_q;
    assign pkt_cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_WAIT;
            rptr_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            rptr_q  <= rptr_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        out_valid = 1'b0;
        rptr_d    = fire ? rptr_q + ONE : rptr_q;
        unique case ({commit, last})
            2'b10:   cnt_d = cnt_q + ONE;
            2'b01:   cnt_d = cnt_q - ONE;
            default: cnt_d = cnt_q;
        endcase
        unique case (state_q)
            RD_WAIT: begin
                if (cnt_q != '0) begin
                    state_d = RD_SEND;
                end
            end
            RD_SEND: begin
                out_valid = 1'b1;
                if (last && cnt_q == ONE && !commit) begin
                    state_d = RD_WAIT;
                end
            end
            default: state_d = RD_WAIT;
        endcase
    end
endmodule

// File: rtl/pkt_sf_fifo.sv
module pkt_sf_fifo #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 512,
    parameter int EMPTY_W = $clog2(DATA_W / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               drop_err_en,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    input  logic               in_err,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_sop,
    output logic               out_eop,
    output logic [EMPTY_W-1:0] out_empty,
    output logic               out_err
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam int WORD_W = DATA_W + EMPTY_W + 3;

    logic              we, commit, pkt_avail;
    logic [PTR_W-1:0]  wptr, rptr, pkt_cnt;
    logic [WORD_W-1:0] wr_word, rd_word;

    assign wr_word   = {in_err, in_empty, in_eop, in_sop, in_data};
    assign pkt_avail = pkt_cnt != '0;

    assign out_data  = rd_word[DATA_W-1:0];
    assign out_sop   = rd_word[DATA_W];
    assign out_eop   = rd_word[DATA_W+1];
    assign out_empty = rd_word[DATA_W+2 +: EMPTY_W];
    assign out_err   = rd_word[WORD_W-1];

    pkt_sf_fifo_wr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .drop_err_en(drop_err_en),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
        .rptr(rptr), .pkt_avail(pkt_avail),
        .in_ready(in_ready), .we(we), .wptr(wptr), .commit(commit)
    );

    pkt_sf_fifo_ram #(.WIDTH(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(we), .waddr(wptr[ADDR_W-1:0]), .wdata(wr_word),
        .raddr(rptr[ADDR_W-1:0]), .rdata(rd_word)
    );

    pkt_sf_fifo_rd_ctrl #(.PTR_W(PTR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .commit(commit), .out_ready(out_ready),
        .rd_eop(out_eop), .out_valid(out_valid), .rptr(rptr), .pkt_cnt(pkt_cnt)
    );
endmodule

// File: rtl/pkt_sf_fifo_checker.sv
module pkt_sf_fifo_checker #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 512,
    parameter int PTR_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drop_err_en,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_sop,
    input logic              in_eop,
    input logic              in_err,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic [PTR_W-1:0]  wptr,
    input logic [PTR_W-1:0]  rptr,
    input logic [PTR_W-1:0]  pkt_cnt
);
    localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr - rptr) <= FULL_LVL);

    assert_ready_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (wptr - rptr) == FULL_LVL);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sop) && $stable(out_eop)));

    assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pkt_cnt != '0);

    assert_drop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sop && in_eop && in_err && drop_err_en)
        |=> pkt_cnt <= $past(pkt_cnt));
endmodule

bind pkt_sf_fifo pkt_sf_fifo_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .drop_err_en(drop_err_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop),
    .wptr(wptr), .rptr(rptr), .pkt_cnt(pkt_cnt)
);

// File: tb/pkt_sf_fifo_test.sv
module pkt_sf_fifo_test;
    localparam int DW  = 64;
    localparam int DEP = 16;
    localparam int EW  = 3;

    typedef struct packed {
        logic          err;
        logic [EW-1:0] empty;
        logic          eop;
        logic          sop;
        logic [DW-1:0] data;
    } beat_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drop_err_en = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [DW-1:0] in_data = '0;
    logic in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
    logic [EW-1:0] in_empty = '0;
    logic out_valid, out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic out_sop, out_eop, out_err;
    logic [EW-1:0] out_empty;

    int  n_chk = 0, n_err = 0;
    bit  rnd_ready = 1'b0;
    bit  ended = 1'b0;
    beat_t exp_q[$];

    pkt_sf_fifo #(.DATA_W(DW), .DEPTH(DEP)) uut (
        .clk(clk), .rst_n(rst_n), .drop_err_en(drop_err_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty), .in_err(in_err),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty), .out_err(out_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    function automatic beat_t mk(input int id, input int i, input int len, input bit err);
        beat_t b;
        b.data  = {id[31:0], i[31:0]};
        b.sop   = (i == 0);
        b.eop   = (i == len - 1);
        b.empty = b.eop ? id[EW-1:0] : '0;
        b.err   = b.eop ? err : 1'b0;
        return b;
    endfunction

    // called at posedge+1; returns at posedge+1 of the accepting edge
    task automatic put_beat(input beat_t b);
        bit acc;
        in_data  = b.data;
        in_sop   = b.sop;
        in_eop   = b.eop;
        in_empty = b.empty;
        in_err   = b.err;
        in_valid = 1'b1;
        acc = 1'b0;
        while (!acc) begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_pkt(input int id, input int len, input bit err, input bit dropped, input int flip_at);
        for (int i = 0; i < len; i++) begin
            beat_t b;
            b = mk(id, i, len, err);
            if (i == flip_at) drop_err_en = ~drop_err_en;
            if (!dropped) exp_q.push_back(b);
            put_beat(b);
        end
        in_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int t = 0; t < 3000 && exp_q.size() != 0; t++) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, tag, 80'(exp_q.size()), 80'd0);
    endtask

    // scoreboard monitor (R2)
    always @(negedge clk) begin
        beat_t got, e;
        if (rst_n && out_valid && out_ready) begin
            got = {out_err, out_empty, out_eop, out_sop, out_data};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected output beat", 80'(got), 80'd0);
            end else begin
                e = exp_q.pop_front();
                chk(got == e, "R2 beat content/order", 80'(got), 80'(e));
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (rnd_ready) out_ready = ($urandom % 4) != 0;
    end

    initial begin
        repeat (40000) @(posedge clk);
        chk(1'b0, "watchdog expired", 80'd0, 80'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 80'(out_valid), 80'd0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 80'(in_ready), 80'd1);
        @(posedge clk); #1;

        // R3 store-and-forward hold
        out_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(mk(1, i, 5, 1'b0));
            put_beat(mk(1, i, 5, 1'b0));
        end
        in_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R3 partial packet held", 80'(out_valid), 80'd0);
        end
        @(posedge clk); #1;
        for (int i = 3; i < 5; i++) begin
            exp_q.push_back(mk(1, i, 5, 1'b0));
            put_beat(mk(1, i, 5, 1'b0));
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R3 not valid one edge after eop", 80'(out_valid), 80'd0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R3 valid two edges after eop", 80'(out_valid), 80'd1);
        drain("R3 packet delivered");
        @(posedge clk); #1;

        // R5 errored packets forwarded with drop disabled
        rnd_ready = 1'b1;
        drop_err_en = 1'b0;
        send_pkt(2, 1, 1'b0, 1'b0, -1);
        send_pkt(3, 4, 1'b1, 1'b0, -1);
        send_pkt(4, 2, 1'b0, 1'b0, -1);
        send_pkt(5, 7, 1'b1, 1'b0, -1);
        drain("R5 errored packets forwarded");

        // R4 drop-on-error
        drop_err_en = 1'b1;
        send_pkt(6, 3, 1'b0, 1'b0, -1);
        send_pkt(7, 5, 1'b1, 1'b1, -1);
        send_pkt(8, 1, 1'b1, 1'b1, -1);
        send_pkt(9, 2, 1'b0, 1'b0, -1);
        drain("R4 good packets around dropped ones");
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R4 nothing from dropped packets", 80'(out_valid), 80'd0);
        @(posedge clk); #1;

        // R6 mode sampled at opening beat
        drop_err_en = 1'b0;
        send_pkt(10, 4, 1'b1, 1'b0, 2);
        send_pkt(11, 4, 1'b1, 1'b1, 2);
        drain("R6 mode change mid-packet ignored");
        rnd_ready = 1'b0;
        drop_err_en = 1'b0;
        @(posedge clk); #1;

        // R7 full buffer and stalled output
        out_ready = 1'b0;
        send_pkt(12, 8, 1'b0, 1'b0, -1);
        send_pkt(13, 8, 1'b0, 1'b0, -1);
        @(negedge clk);
        chk(in_ready == 1'b0, "R7 in_ready low when full", 80'(in_ready), 80'd0);
        chk(out_valid == 1'b1, "R7 out_valid while stalled", 80'(out_valid), 80'd1);
        begin
            logic [DW-1:0] held;
            held = out_data;
            repeat (3) @(negedge clk);
            chk(out_data == held && out_valid, "R7 output held under stall", 80'(out_data), 80'(held));
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
        drain("R7 drained after stall");

        // R10 back-to-back packets
        out_ready = 1'b0;
        send_pkt(14, 3, 1'b0, 1'b0, -1);
        send_pkt(15, 3, 1'b0, 1'b0, -1);
        repeat (2) @(posedge clk);
        #1 out_ready = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R10 no gap between stored packets", 80'(out_valid), 80'd1);
        end
        drain("R10 drained");

        // R8 oversize packet discarded, exact-depth kept
        send_pkt(16, DEP + 4, 1'b0, 1'b1, -1);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R8 oversize packet discarded", 80'(out_valid), 80'd0);
        @(posedge clk); #1;
        send_pkt(17, 3, 1'b0, 1'b0, -1);
        drain("R8 traffic resumes after oversize");
        send_pkt(18, DEP, 1'b0, 1'b0, -1);
        drain("R8 exact-depth packet kept");

        // R9 stray beat outside a packet
        begin
            beat_t s;
            s = mk(19, 1, 2, 1'b0);
            put_beat(s);
            in_valid = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R9 stray beat discarded", 80'(out_valid), 80'd0);
        @(posedge clk); #1;
        send_pkt(20, 2, 1'b0, 1'b0, -1);
        drain("R9 next packet intact");

        chk(exp_q.size() == 0, "R2 all kept packets delivered", 80'(exp_q.size()), 80'd0);
        finish_run();
    end
endmodule